// File: doc/BRIEF.md
# Stream-Fed Serial Transmitter

This block turns parallel data words into an asynchronous serial frame on one output line. Words arrive on a valid/ready stream sink. The block takes a word only in a cycle where the source offers it and the block is ready. Each word is sent as one low start bit, the data bits least significant first, and one high stop bit. Between frames the line rests high. The line is driven straight from a flip-flop, so it does not glitch.

The bit rate is set at run time by a divider input. Each bit lasts eight divider periods, so a bit takes eight times the divider value in clock cycles. The divider is not buffered, so it should be changed only while the block is idle. A busy output is high for the whole frame. The sink accepts nothing until the stop bit has fully elapsed.

Top module: `uart_serializer`

## Requirements
- R1: While reset is asserted, and right after it, `line_o` is 1, `s_ready_o` is 1 and `active_o` is 0. Asserting reset in the middle of a frame returns the block to this state at once.
- R2: A word is taken only on a clock edge where `s_valid_i` and `s_ready_o` are both 1. In the cycle after that edge, `s_ready_o` is 0 and `active_o` is 1.
- R3: The frame starts with a low start bit. Then come the DATA_W bits of the accepted word, bit 0 first. Then comes one high stop bit.
- R4: Every bit, the start and stop bits included, holds for 8·P clock cycles. P is `rate_div_i`, with a value of 0 treated as 1. The start bit begins at the accept edge.
- R5: `active_o` stays 1 and `s_ready_o` stays 0 for (DATA_W+2)·8·P cycles after the accept edge. Both change back in the cycle after that. With `s_valid_i` held high, the next word is accepted on the very next edge.
- R6: Changes on `s_data_i` after the accept edge have no effect on the frame in progress.
- R7: While `s_valid_i` is 0 the block stays idle, with `line_o` at 1 and `active_o` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rate_div_i | input | DIV_W | Divider P; one bit lasts 8·P cycles; 0 acts as 1 |
| s_data_i | input | DATA_W | Word offered by the source |
| s_valid_i | input | 1 | Source offers a word |
| s_ready_o | output | 1 | Block can accept a word |
| line_o | output | 1 | Serial line; rests high |
| active_o | output | 1 | A frame is being sent |

## Verification
The bench uses a behavioural receiver that samples the middle of every bit. Alternating, all-zero, all-one and edge-bit patterns separate a bit-order fault from a stuck shift stage and from a wrong start or stop level. Divider values 0 through 4 check that the bit length scales with P and that 0 does not wrap. Two back-to-back words with valid held high show the one-cycle idle gap. Changing the source data mid-frame and resetting mid-frame show that neither disturbs the rules above.

// File: rtl/uart_ser_pkg.sv
package uart_ser_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SEND = 1'b1
  } ser_state_e;

  localparam int unsigned TICKS_PER_BIT = 8;
endpackage

// File: rtl/uart_ser_baud.sv
module uart_ser_baud #(
  parameter int unsigned DIV_W = 16,
  parameter int unsigned TICKS = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             bit_end_o
);
  localparam int unsigned TICK_W = (TICKS > 1) ? $clog2(TICKS) : 1;
  localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(TICKS - 1);

  logic [DIV_W-1:0]  pcnt_q, pcnt_d, limit;
  logic [TICK_W-1:0] tcnt_q, tcnt_d;
  logic              tick, cnt_en;

  // divider read live each cycle; >= keeps a shrinking divider from overrunning
  assign limit     = (div_i == '0) ? '0 : div_i - DIV_W'(1);
  assign tick      = run_i && (pcnt_q >= limit);
  assign bit_end_o = tick && (tcnt_q == TICK_LAST);
  assign cnt_en    = run_i || (pcnt_q != '0) || (tcnt_q != '0);

  always_comb begin
    pcnt_d = pcnt_q;
    tcnt_d = tcnt_q;
    if (!run_i) begin
      pcnt_d = '0;
      tcnt_d = '0;
    end else if (tick) begin
      pcnt_d = '0;
      tcnt_d = bit_end_o ? '0 : tcnt_q + TICK_W'(1);
    end else begin
      pcnt_d = pcnt_q + DIV_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pcnt_q <= '0;
      tcnt_q <= '0;
    end else if (cnt_en) begin
      pcnt_q <= pcnt_d;
      tcnt_q <= tcnt_d;
    end
  end
endmodule

// File: rtl/uart_ser_shift.sv
module uart_ser_shift #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              adv_i,
  output logic              line_o,
  output logic              last_o
);
  localparam int unsigned FRAME_W = DATA_W + 2;
  localparam int unsigned CNT_W   = $clog2(FRAME_W);

  logic [FRAME_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]   left_q, left_d;
  logic               sh_en;

  assign sh_en  = load_i || adv_i;
  assign line_o = sh_q[0];
  assign last_o = (left_q == '0);

  always_comb begin
    sh_d   = sh_q;
    left_d = left_q;
    if (load_i) begin
      sh_d   = {1'b1, data_i, 1'b0};
      left_d = CNT_W'(FRAME_W - 1);
    end else if (adv_i) begin
      sh_d   = {1'b1, sh_q[FRAME_W-1:1]};
      left_d = last_o ? '0 : left_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '1;
      left_q <= '0;
    end else if (sh_en) begin
      sh_q   <= sh_d;
      left_q <= left_d;
    end
  end

  assert_load_start_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> !line_o);
  assert_stop_high_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && last_o) |-> line_o);
endmodule

// File: rtl/uart_serializer.sv
module uart_serializer
  import uart_ser_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DIV_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DIV_W-1:0]  rate_div_i,
  input  logic [DATA_W-1:0] s_data_i,
  input  logic              s_valid_i,
  output logic              s_ready_o,
  output logic              line_o,
  output logic              active_o
);
  ser_state_e state_q, state_d;
  logic       accept, bit_end, last_bit;

  assign s_ready_o = (state_q == ST_IDLE);
  assign active_o  = (state_q == ST_SEND);
  assign accept    = s_valid_i && s_ready_o;

  uart_ser_baud #(
    .DIV_W (DIV_W),
    .TICKS (TICKS_PER_BIT)
  ) u_baud (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (active_o),
    .div_i     (rate_div_i),
    .bit_end_o (bit_end)
  );

  uart_ser_shift #(
    .DATA_W (DATA_W)
  ) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept),
    .data_i (s_data_i),
    .adv_i  (bit_end),
    .line_o (line_o),
    .last_o (last_bit)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept)              state_d = ST_SEND;
      ST_SEND: if (bit_end && last_bit) state_d = ST_IDLE;
      default:                          state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assert_accept_drops_ready_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> (!s_ready_o && active_o));
  assert_idle_line_high_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_o |-> line_o);
  assert_busy_holds_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && !bit_end) |=> active_o);
  assert_bit_end_busy_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_end |-> active_o);
endmodule

// File: tb/uart_serializer_tb.sv
module uart_serializer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 8;
  localparam int DIV_W  = 16;
  localparam int NVEC   = 6;

  // stimulus word, divider, expected frame length in cycles
  localparam logic [7:0] T_DATA [NVEC] = '{8'h55, 8'hA3, 8'h00, 8'hFF, 8'h81, 8'h3C};
  localparam int         T_DIV  [NVEC] = '{1, 2, 1, 3, 0, 4};
  localparam int         T_LEN  [NVEC] = '{80, 160, 80, 240, 80, 320};

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [DIV_W-1:0]  rate_div_i = '0;
  logic [DATA_W-1:0] s_data_i = '0;
  logic              s_valid_i = 1'b0;
  logic              s_ready_o, line_o, active_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  uart_serializer #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_dut (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rate_div_i (rate_div_i),
    .s_data_i   (s_data_i),
    .s_valid_i  (s_valid_i),
    .s_ready_o  (s_ready_o),
    .line_o     (line_o),
    .active_o   (active_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // behavioural receiver: offers word, waits for accept, samples each bit mid-way
  task automatic send_frame(input logic [7:0] data, input int div, input int exp_len,
                            input logic [7:0] after_data, input bit hold, output int waits);
    int p, f, k, bitv;
    p = (div == 0) ? 1 : div;
    f = exp_len;
    s_data_i  = data;
    s_valid_i = 1'b1;
    waits = 0;
    while (!s_ready_o) begin
      @(negedge clk_i);
      waits++;
    end
    @(posedge clk_i);
    @(negedge clk_i);
    s_data_i  = after_data; // R6: must not disturb the frame
    s_valid_i = hold;
    for (int i = 0; i <= f; i++) begin
      if (i == 0) chk("R2 ready low after accept", s_ready_o, 0);
      if (i == 0) chk("R2 busy after accept", active_o, 1);
      if ((i % (8*p)) == 4*p && i < f) begin
        k = i / (8*p);
        bitv = (k == 0) ? 0 : (k <= DATA_W) ? data[k-1] : 1;
        chk($sformatf("R3/R6 bit %0d of %02h", k, data), line_o, bitv);
      end
      if (i == 8*p - 1) chk("R4 start bit still low at its last cycle", line_o, 0);
      if (i == 8*p && DATA_W > 0) chk("R4 first data bit at 8P", line_o, data[0]);
      if (i == f-1) chk("R5 still busy at end of stop bit", active_o, 1);
      if (i == f) begin
        chk("R5 ready back after frame", s_ready_o, 1);
        chk("R5 busy clear after frame", active_o, 0);
        chk("R5 line high after frame", line_o, 1);
      end
      if (i < f) @(negedge clk_i);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int w;
    rate_div_i = 16'd1;
    #(CLK_PERIOD*2 + 1);
    chk("R1 line in reset", line_o, 1);
    chk("R1 ready in reset", s_ready_o, 1);
    chk("R1 busy in reset", active_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 line after reset", line_o, 1);
    chk("R1 busy after reset", active_o, 0);

    // table of vectors
    for (int v = 0; v < NVEC; v++) begin
      rate_div_i = DIV_W'(T_DIV[v]);
      send_frame(T_DATA[v], T_DIV[v], T_LEN[v], ~T_DATA[v], 1'b0, w);
    end

    // R7: idle while valid low
    for (int i = 0; i < 40; i++) begin
      @(negedge clk_i);
      if (line_o != 1'b1 || active_o != 1'b0) begin
        chk("R7 idle with valid low", {line_o, active_o}, 2);
        break;
      end
    end
    chk("R7 no frame started", active_o, 0);

    // R5: back to back with valid held
    rate_div_i = 16'd1;
    send_frame(8'hC6, 1, 80, 8'h29, 1'b1, w);
    send_frame(8'h29, 1, 80, 8'h00, 1'b0, w);
    chk("R5 back-to-back accept with no wait", w, 0);

    // R1: reset in mid-frame
    s_data_i = 8'h00;
    s_valid_i = 1'b1;
    @(negedge clk_i);
    s_valid_i = 1'b0;
    repeat (20) @(negedge clk_i);
    chk("R1 busy before mid reset", active_o, 1);
    rst_ni = 1'b0;
    #1;
    chk("R1 line after mid-frame reset", line_o, 1);
    chk("R1 ready after mid-frame reset", s_ready_o, 1);
    chk("R1 busy after mid-frame reset", active_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    send_frame(8'h96, 1, 80, 8'h00, 1'b0, w);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule